// File: doc/BRIEF.md
# Banked Performance Counter Unit

This unit counts hardware events for software profiling. It holds four pairs of 32-bit counters. Each counter has its own event selector, which picks one of sixteen event pulse inputs. Software reaches the unit through two registers on a plain register port, selected by `reg_addr`:

- The control register holds the bank select, the mode enables, the two write-protect bits, the selections of the currently selected pair, the pair-count field and all overflow flags.
- The counter register reads or loads the whole 64-bit pair that the bank select currently names.

Counting is gated by a user-mode enable and a system-mode enable. The `priv_sys` input chooses which of the two applies in a given cycle. Two protect bits travel with each control write:

- The selection-protect bit keeps the addressed pair's event selections as they are.
- The overflow-protect bit keeps the overflow flags as they are.

With these bits, software can start, stop or re-bank the counters without rewriting event choices or losing overflow status.

The register port and the event vector are sampled on every clock. They carry no valid/ready handshake, so the unit never applies back-pressure. A write is taken in the cycle `reg_we` is high. A read is combinational from `reg_addr` and the present state.

Top module: `perf_ctr_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all counters, all event selections, the bank select, both enables and all overflow flags.
- R2: The bank select field (control bits 1:0) names the pair that a counter-register access (`reg_addr`=1) reads and loads. Reading never changes any state.
- R3: On a control write, the event selections of the pair named by the written bank select take the written values when bit 10 is 0: lower selection from bits 19:16, upper selection from bits 27:24. When bit 10 is 1, they stay unchanged.
- R4: On a control write with bit 11 at 0, all overflow flags take written bits 47:40. Bit 40+2p belongs to pair p's lower counter and bit 41+2p to its upper counter. With bit 11 at 1, the flags are left as they were.
- R5: A counter increments by one in a cycle where its selected event pulse is high and the active enable is 1. The active enable is the system enable (control bit 9) when `priv_sys` is 1, and the user enable (control bit 8) otherwise.
- R6: With both enables at 0, no counter changes except through a counter-register write.
- R7: Control bits 39:32 always read as the number of pairs minus one (3), whatever is written there.
- R8: A counter-register write loads `reg_wdata` into the selected pair: bits 31:0 go to the lower counter and bits 63:32 to the upper counter. If an increment hits the same pair in the same cycle, the written value wins.
- R9: A counter that counts from all ones to zero sets its overflow flag. The flag stays set until a control write clears it under R4.
- R10: A control read returns the bank select, both enables, the selected pair's two event selections, the pair count and all overflow flags. Bits 10, 11 and all unassigned bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = counter register |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| ev_pulse | input | 16 | Event pulse vector, one bit per event |
| priv_sys | input | 1 | 1 = system mode, 0 = user mode |

## Verification
Several rules are checked on every cycle against internal state:

- The protect bits either freeze the selections or hold the overflow flags so that they can only rise.
- An unprotected control write loads the flags exactly.
- A counter write lands in the pair selected before that write.
- Counters stay frozen while the active enable is off.
- The pair-count field never changes.

Some behaviours can only be shown by the bench's scenarios, where a cycle-accurate model tracks every counter:

- the exact increment per event pulse;
- the choice between the user and system enables;
- wrap into an overflow flag;
- the collision of a counter write with an increment;
- the read layout of each pair.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int REG_W   = 64;
  localparam int F_SEL   = 0;
  localparam int F_UEN   = 8;
  localparam int F_SEN   = 9;
  localparam int F_SRO   = 10;
  localparam int F_ORO   = 11;
  localparam int F_EVLO  = 16;
  localparam int F_EVHI  = 24;
  localparam int F_NC    = 32;
  localparam int NC_W    = 8;
  localparam int F_OVF   = 40;

  typedef enum logic {
    A_CTL = 1'b0,
    A_CNT = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/perf_ctl_regs.sv
module perf_ctl_regs #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [SEL_W-1:0] sel_w,
  input  logic             uen_w,
  input  logic             sen_w,
  input  logic             priv_sys,
  output logic [SEL_W-1:0] sel_q,
  output logic             uen_q,
  output logic             sen_q,
  output logic             cnt_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      uen_q <= 1'b0;
      sen_q <= 1'b0;
    end else if (ctl_we) begin
      sel_q <= sel_w;
      uen_q <= uen_w;
      sen_q <= sen_w;
    end
  end

  // active enable follows current privilege
  assign cnt_en = priv_sys ? sen_q : uen_q;
endmodule

// File: rtl/perf_ctr_half.sv
module perf_ctr_half #(
  parameter int CNT_W      = 32,
  parameter int NUM_EVENTS = 16,
  parameter int EV_W       = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_EVENTS-1:0] ev_pulse,
  input  logic                  cnt_en,
  input  logic                  sel_we,
  input  logic [EV_W-1:0]       sel_wval,
  input  logic                  ld_en,
  input  logic [CNT_W-1:0]      ld_val,
  input  logic                  ovf_we,
  input  logic                  ovf_wval,
  output logic [CNT_W-1:0]      cnt,
  output logic [EV_W-1:0]       evsel,
  output logic                  ovf_flag
);
  logic hit;
  assign hit = cnt_en && ev_pulse[evsel];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      evsel    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (sel_we) evsel <= sel_wval;
      if (ld_en)    cnt <= ld_val;
      else if (hit) cnt <= cnt + 1'b1;
      if (ovf_we) ovf_flag <= ovf_wval;
      else if (!ld_en && hit && (&cnt)) ovf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/perf_ctr_pair.sv
module perf_ctr_pair #(
  parameter int CNT_W      = 32,
  parameter int NUM_EVENTS = 16,
  parameter int EV_W       = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_EVENTS-1:0] ev_pulse,
  input  logic                  cnt_en,
  input  logic                  sel_we,
  input  logic [2*EV_W-1:0]     sel_wval,
  input  logic                  ld_en,
  input  logic [2*CNT_W-1:0]    ld_val,
  input  logic                  ovf_we,
  input  logic [1:0]            ovf_wval,
  output logic [2*CNT_W-1:0]    cnt,
  output logic [2*EV_W-1:0]     evsel,
  output logic [1:0]            ovf
);
  // half 0 = lower counter, half 1 = upper counter
  for (genvar h = 0; h < 2; h++) begin : g_half
    perf_ctr_half #(.CNT_W(CNT_W), .NUM_EVENTS(NUM_EVENTS), .EV_W(EV_W)) u_half (
      .clk      (clk),
      .rst      (rst),
      .ev_pulse (ev_pulse),
      .cnt_en   (cnt_en),
      .sel_we   (sel_we),
      .sel_wval (sel_wval[h*EV_W +: EV_W]),
      .ld_en    (ld_en),
      .ld_val   (ld_val[h*CNT_W +: CNT_W]),
      .ovf_we   (ovf_we),
      .ovf_wval (ovf_wval[h]),
      .cnt      (cnt[h*CNT_W +: CNT_W]),
      .evsel    (evsel[h*EV_W +: EV_W]),
      .ovf_flag (ovf[h])
    );
  end
endmodule

// File: rtl/perf_ctr_unit.sv
module perf_ctr_unit
  import perf_pkg::*;
#(
  parameter int NUM_PAIRS  = 4,
  parameter int NUM_EVENTS = 16,
  parameter int CNT_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_we,
  input  logic                  reg_addr,
  input  logic [2*CNT_W-1:0]    reg_wdata,
  output logic [2*CNT_W-1:0]    reg_rdata,
  input  logic [NUM_EVENTS-1:0] ev_pulse,
  input  logic                  priv_sys
);
  localparam int SEL_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
  localparam int EV_W  = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;
  localparam int PW    = 2 * CNT_W;
  localparam int NOVF  = 2 * NUM_PAIRS;

  logic             ctl_we, cnt_we, cnt_en, uen_q, sen_q;
  logic [SEL_W-1:0] sel_q, wsel;
  logic [NUM_PAIRS*PW-1:0]     cnt_flat;
  logic [NUM_PAIRS*2*EV_W-1:0] evsel_flat;
  logic [NOVF-1:0]             ovf_all;

  assign ctl_we = reg_we && (reg_addr == A_CTL);
  assign cnt_we = reg_we && (reg_addr == A_CNT);
  assign wsel   = reg_wdata[F_SEL +: SEL_W];

  perf_ctl_regs #(.SEL_W(SEL_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .ctl_we   (ctl_we),
    .sel_w    (wsel),
    .uen_w    (reg_wdata[F_UEN]),
    .sen_w    (reg_wdata[F_SEN]),
    .priv_sys (priv_sys),
    .sel_q    (sel_q),
    .uen_q    (uen_q),
    .sen_q    (sen_q),
    .cnt_en   (cnt_en)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    perf_ctr_pair #(.CNT_W(CNT_W), .NUM_EVENTS(NUM_EVENTS), .EV_W(EV_W)) u_pair (
      .clk      (clk),
      .rst      (rst),
      .ev_pulse (ev_pulse),
      .cnt_en   (cnt_en),
      .sel_we   (ctl_we && !reg_wdata[F_SRO] && (wsel == SEL_W'(p))),
      .sel_wval ({reg_wdata[F_EVHI +: EV_W], reg_wdata[F_EVLO +: EV_W]}),
      .ld_en    (cnt_we && (sel_q == SEL_W'(p))),
      .ld_val   (reg_wdata),
      .ovf_we   (ctl_we && !reg_wdata[F_ORO]),
      .ovf_wval (reg_wdata[F_OVF + 2*p +: 2]),
      .cnt      (cnt_flat[p*PW +: PW]),
      .evsel    (evsel_flat[p*2*EV_W +: 2*EV_W]),
      .ovf      (ovf_all[2*p +: 2])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CNT) begin
      reg_rdata = cnt_flat[sel_q*PW +: PW];
    end else begin
      reg_rdata[F_SEL +: SEL_W] = sel_q;
      reg_rdata[F_UEN]          = uen_q;
      reg_rdata[F_SEN]          = sen_q;
      reg_rdata[F_EVLO +: EV_W] = evsel_flat[sel_q*2*EV_W +: EV_W];
      reg_rdata[F_EVHI +: EV_W] = evsel_flat[sel_q*2*EV_W + EV_W +: EV_W];
      reg_rdata[F_NC +: NC_W]   = NC_W'(NUM_PAIRS - 1);
      reg_rdata[F_OVF +: NOVF]  = ovf_all;
    end
  end
endmodule

// File: rtl/perf_ctr_unit_chk.sv
module perf_ctr_unit_chk
  import perf_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int CNT_W     = 32,
  parameter int SEL_W     = 2,
  parameter int EV_W      = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          reg_we,
  input logic                          reg_addr,
  input logic [2*CNT_W-1:0]            reg_wdata,
  input logic [2*CNT_W-1:0]            reg_rdata,
  input logic                          priv_sys,
  input logic [SEL_W-1:0]              sel_q,
  input logic                          uen_q,
  input logic                          sen_q,
  input logic [NUM_PAIRS*2*CNT_W-1:0]  cnt_flat,
  input logic [NUM_PAIRS*2*EV_W-1:0]   evsel_flat,
  input logic [2*NUM_PAIRS-1:0]        ovf_all
);
  localparam int PW = 2 * CNT_W;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cnt_flat == '0 && evsel_flat == '0 && ovf_all == '0 && sel_q == '0)); // R1

  AST_SEL_PROTECT: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_CTL && reg_wdata[F_SRO]) |=> $stable(evsel_flat)); // R3

  AST_OVF_PROTECT: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_CTL && reg_wdata[F_ORO]) |=> (($past(ovf_all) & ~ovf_all) == '0)); // R4

  AST_OVF_LOAD: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_CTL && !reg_wdata[F_ORO])
      |=> (ovf_all == $past(reg_wdata[F_OVF +: 2*NUM_PAIRS]))); // R4

  AST_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!(priv_sys ? sen_q : uen_q) && !(reg_we && reg_addr == A_CNT)) |=> $stable(cnt_flat)); // R6

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_CNT) |=> (cnt_flat[$past(sel_q)*PW +: PW] == $past(reg_wdata))); // R8

  AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_CTL) |-> (reg_rdata[F_NC +: NC_W] == NC_W'(NUM_PAIRS - 1))); // R7
endmodule

bind perf_ctr_unit perf_ctr_unit_chk #(
  .NUM_PAIRS(NUM_PAIRS), .CNT_W(CNT_W), .SEL_W(SEL_W), .EV_W(EV_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .priv_sys   (priv_sys),
  .sel_q      (sel_q),
  .uen_q      (uen_q),
  .sen_q      (sen_q),
  .cnt_flat   (cnt_flat),
  .evsel_flat (evsel_flat),
  .ovf_all    (ovf_all)
);

// File: tb/perf_ctr_unit_bench.sv
module perf_ctr_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [15:0] ev_pulse = '0;
  logic        priv_sys = 1'b0;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  perf_ctr_unit u_perf_ctr_unit (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_pulse(ev_pulse), .priv_sys(priv_sys)
  );

  // behavioural reference model
  int unsigned m_lo[4], m_hi[4];
  int          m_evlo[4], m_evhi[4];
  bit          m_ovf[8], m_wrap[8];
  int          m_sel, s_old;
  bit          m_uen, m_sen, m_en;

  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 4; p++) begin
        m_lo[p] = 0; m_hi[p] = 0; m_evlo[p] = 0; m_evhi[p] = 0;
      end
      for (int i = 0; i < 8; i++) m_ovf[i] = 0;
      m_sel = 0; m_uen = 0; m_sen = 0;
    end else begin
      m_en = priv_sys ? m_sen : m_uen;
      s_old = m_sel;
      for (int i = 0; i < 8; i++) m_wrap[i] = 0;
      for (int p = 0; p < 4; p++) begin
        if (m_en && ev_pulse[m_evlo[p]]) begin
          if (m_lo[p] == 32'hFFFF_FFFF) m_wrap[2*p] = 1;
          m_lo[p] = m_lo[p] + 1;
        end
        if (m_en && ev_pulse[m_evhi[p]]) begin
          if (m_hi[p] == 32'hFFFF_FFFF) m_wrap[2*p+1] = 1;
          m_hi[p] = m_hi[p] + 1;
        end
      end
      if (reg_we && reg_addr) begin
        m_lo[s_old] = reg_wdata[31:0];
        m_hi[s_old] = reg_wdata[63:32];
        m_wrap[2*s_old] = 0;
        m_wrap[2*s_old+1] = 0;
      end
      if (reg_we && !reg_addr) begin
        m_sel = int'(reg_wdata[1:0]);
        m_uen = reg_wdata[8];
        m_sen = reg_wdata[9];
        if (!reg_wdata[10]) begin
          m_evlo[m_sel] = int'(reg_wdata[19:16]);
          m_evhi[m_sel] = int'(reg_wdata[27:24]);
        end
      end
      for (int i = 0; i < 8; i++) begin
        if (reg_we && !reg_addr && !reg_wdata[11]) m_ovf[i] = reg_wdata[40+i];
        else if (m_wrap[i]) m_ovf[i] = 1;
      end
    end
  end

  function automatic logic [63:0] expect_rd(input logic a);
    logic [63:0] e;
    e = '0;
    if (a) begin
      e = {m_hi[m_sel], m_lo[m_sel]};
    end else begin
      e[1:0]   = 2'(m_sel);
      e[8]     = m_uen;
      e[9]     = m_sen;
      e[19:16] = 4'(m_evlo[m_sel]);
      e[27:24] = 4'(m_evhi[m_sel]);
      e[39:32] = 8'd3;
      for (int i = 0; i < 8; i++) e[40+i] = m_ovf[i];
    end
    return e;
  endfunction

  task automatic step(input bit we, input bit a, input logic [63:0] wd,
                      input logic [15:0] ev, input bit sys, input bit chk, input string tag);
    logic [63:0] exp_v;
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd; ev_pulse = ev; priv_sys = sys;
    #1;
    if (chk) begin
      exp_v = expect_rd(a);
      vectors++;
      if (reg_rdata !== exp_v) begin
        fails++;
        $display("FAIL %s: addr=%0d rdata=%h expected=%h", tag, a, reg_rdata, exp_v);
      end
    end
  endtask

  // control word helper: sel, uen, sen, sro, oro, evlo, evhi, ovf
  function automatic logic [63:0] ctl(input int s, input bit u, input bit y, input bit sro,
                                       input bit oro, input int lo, input int hi, input logic [7:0] ov);
    logic [63:0] w;
    w = '0;
    w[1:0] = 2'(s); w[8] = u; w[9] = y; w[10] = sro; w[11] = oro;
    w[19:16] = 4'(lo); w[27:24] = 4'(hi); w[47:40] = ov;
    return w;
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    step(0, 0, '0, '0, 0, 0, "R1");
    step(0, 0, '0, '0, 0, 0, "R1");
    rst = 1'b0;
    step(0, 0, '0, '0, 0, 1, "R1");   // reset state of control, R7 field
    step(0, 1, '0, '0, 0, 1, "R1");
    // R3: load selections of pair 2
    step(1, 0, ctl(2, 0, 0, 0, 1, 3, 5, 8'h00), '0, 0, 1, "R3");
    step(0, 0, '0, '0, 0, 1, "R3");
    step(1, 0, ctl(2, 0, 0, 1, 1, 7, 9, 8'h00), '0, 0, 1, "R3");
    step(0, 0, '0, '0, 0, 1, "R3");
    // R8: load pair 2 near wrap; R7 write ignored
    step(1, 1, 64'h0000_0005_FFFF_FFFE, '0, 0, 1, "R8");
    step(0, 1, '0, '0, 0, 1, "R8");
    step(1, 0, ctl(2, 1, 0, 1, 1, 0, 0, 8'h00) | 64'h0000_00FF_0000_0000, '0, 0, 1, "R7");
    step(0, 0, '0, '0, 0, 1, "R7");
    // R5/R9: user mode counts, lower wraps
    for (int k = 0; k < 4; k++) step(0, 1, '0, 16'h0028, 0, 1, "R5");
    step(0, 0, '0, '0, 0, 1, "R9");
    // R5: system mode with only user enable: no count
    for (int k = 0; k < 3; k++) step(0, 1, '0, 16'hFFFF, 1, 1, "R5");
    // R6: both enables off
    step(1, 0, ctl(2, 0, 0, 1, 1, 0, 0, 8'h00), '0, 0, 1, "R6");
    for (int k = 0; k < 3; k++) step(0, 1, '0, 16'hFFFF, k[0], 1, "R6");
    // R4: protected then unprotected overflow writes
    step(1, 0, ctl(2, 0, 1, 1, 1, 0, 0, 8'h00), '0, 1, 1, "R4");
    step(0, 0, '0, '0, 1, 1, "R4");
    step(1, 0, ctl(2, 0, 1, 1, 0, 0, 0, 8'hA5), '0, 1, 1, "R4");
    step(0, 0, '0, '0, 1, 1, "R4");
    step(1, 0, ctl(2, 0, 1, 1, 0, 0, 0, 8'h00), '0, 1, 1, "R4");
    // R8: write collides with increment
    step(1, 1, 64'h1234_5678_9ABC_DEF0, 16'hFFFF, 1, 1, "R8");
    step(0, 1, '0, '0, 1, 1, "R8");
    // R2: other bank read and load, pair 2 kept
    step(1, 0, ctl(1, 0, 0, 1, 1, 0, 0, 8'h00), '0, 0, 1, "R2");
    step(0, 1, '0, '0, 0, 1, "R2");
    step(1, 1, 64'h0000_0001_0000_0002, '0, 0, 1, "R2");
    step(1, 0, ctl(2, 0, 0, 1, 1, 0, 0, 8'h00), '0, 0, 1, "R2");
    step(0, 1, '0, '0, 0, 1, "R2");
    step(0, 0, '0, '0, 0, 1, "R10");
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [63:0] wd;
      bit we, a;
      wd = {$urandom, $urandom};
      we = ($urandom_range(0, 3) == 0);
      a  = $urandom_range(0, 1);
      if (we && a && $urandom_range(0, 1)) wd[31:0] = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
      step(we, a, wd, 16'($urandom), $urandom_range(0, 1), 1, a ? "R5" : "R10");
    end
    step(0, 0, '0, '0, 0, 1, "R10");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule